// File: doc/BRIEF.md
# Flash Control Register Key Lock

This block guards the program/erase control register of an embedded flash controller. It listens to 32-bit register writes on a simple strobe interface. It holds the control register and three lock bits inside it: one for the register itself, one for program memory and one for the option area.

Each lock bit is cleared only by writing an exact ordered pair of 32-bit magic words to that lock's key register. The program-memory and option locks can be opened only after the control-register lock is open. Software relocks by writing ones to the lock bits.

A wrong key value, or a second key word that arrives without its first word, trips a sticky lockout. The lockout holds all three locks closed until reset. While the control register is locked, the non-lock control fields cannot be changed.

Top module: `flash_key_lock`

## Requirements
- R1: After reset the control register reads 0x0000_0007: bit0 (register lock), bit1 (program lock) and bit2 (option lock) are 1, every other bit is 0, and `lockout` is 0.
- R2: Writing 0x89ABCDEF and then 0x02030405 to byte offset 0x0C clears bit0 on the write of the second word.
- R3: Writing 0x8C9DAEBF and then 0x13141516 to offset 0x10 clears bit1, but only when bit0 is already 0.
- R4: Writing 0xFBEAD9C8 and then 0x24252627 to offset 0x14 clears bit2, but only when bit0 is already 0.
- R5: A correct program or option key pair written while bit0 is 1 changes no lock bit and does not raise `lockout`.
- R6: Any of the following at a key offset sets `lockout`:
  - a value that is neither expected word;
  - a second word with no first word before it;
  - a first word written twice.
  `lockout` stays 1 and all three lock bits stay 1 until reset, and later correct key pairs have no effect.
- R7: A write to the control register at offset 0x04 updates bits 3, 4, 8, 9, 10, 16, 17 and 18 only if bit0 is 0 before the write. Undefined bits always read 0.
- R8: Writing 1 to a lock bit sets it. Writing 0 to a lock bit never clears it; only a key pair does.
- R9: Setting bit0 also forces bit1 and bit2 to 1, so bit0 = 1 always implies bit1 = bit2 = 1.
- R10: With `rd_en` high, `rd_data` returns the control register for offset 0x04 and 0 for any other offset. `ctrl_locked`, `prog_locked` and `opt_locked` follow bits 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data (control register at 0x04, else 0) |
| ctrl_word | output | 32 | Current control register contents |
| ctrl_locked | output | 1 | Control-register lock (bit0) |
| prog_locked | output | 1 | Program-memory lock (bit1) |
| opt_locked | output | 1 | Option lock (bit2) |
| lockout | output | 1 | Sticky flag after a bad key sequence |

## Verification
The assertions check three properties on every cycle:
- the lock ordering invariant (bit0 implies bits 1 and 2);
- that a lock bit only falls after a key pass, and the program and option locks only while the register lock was already open;
- the stickiness of the lockout together with its forcing of the locks, and the freezing of the control fields while locked.

Only the bench scenarios can show the exact key words and offsets that open each lock. They also show which malformed sequences trip the lockout, that a correct program key pair is silently ignored while the register is locked, and the read-port decode.

// File: rtl/fkl_pkg.sv
package fkl_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam int N_LOCK = 3;

    typedef enum logic [1:0] {
        LK_CTRL = 2'd0,
        LK_PROG = 2'd1,
        LK_OPT  = 2'd2
    } lock_id_e;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CKEY = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_PKEY = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_OKEY = 6'h14;

    // writable non-lock fields: bits 3,4,8,9,10,16,17,18
    localparam logic [DATA_W-1:0] FIELD_MASK = 32'h0007_0718;
    localparam logic [DATA_W-1:0] LOCK_MASK  = 32'h0000_0007;

    typedef struct packed {
        logic [DATA_W-1:0] first;
        logic [DATA_W-1:0] second;
    } key_pair_t;

    function automatic key_pair_t key_of(input int idx);
        key_pair_t k;
        case (idx)
            0:       k = '{first: 32'h89AB_CDEF, second: 32'h0203_0405};
            1:       k = '{first: 32'h8C9D_AEBF, second: 32'h1314_1516};
            default: k = '{first: 32'hFBEA_D9C8, second: 32'h2425_2627};
        endcase
        return k;
    endfunction

    function automatic logic [ADDR_W-1:0] key_ofs(input int idx);
        case (idx)
            0:       return OFS_CKEY;
            1:       return OFS_PKEY;
            default: return OFS_OKEY;
        endcase
    endfunction
endpackage

// File: rtl/fkl_key_seq.sv
module fkl_key_seq
    import fkl_pkg::*;
#(
    parameter int                W      = DATA_W,
    parameter logic [DATA_W-1:0] FIRST  = '0,
    parameter logic [DATA_W-1:0] SECOND = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hit,
    input  logic [W-1:0] wdata,
    output logic         pass,
    output logic         fault
);
    logic armed_q;

    always_comb begin
        pass  = hit && armed_q && (wdata == SECOND[W-1:0]);
        fault = hit && (armed_q ? (wdata != SECOND[W-1:0]) : (wdata != FIRST[W-1:0]));
    end

    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b0;
        else if (hit)
            armed_q <= !armed_q && (wdata == FIRST[W-1:0]);
    end

    // R6
    seq_disarm_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> !armed_q);
endmodule

// File: rtl/fkl_ctrl_reg.sv
module fkl_ctrl_reg
    import fkl_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int L = N_LOCK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [L-1:0] open_req,
    input  logic         force_lock,
    output logic [W-1:0] ctrl_q
);
    logic [W-1:0] ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (force_lock) begin
            ctrl_d[L-1:0] = '1;
        end else begin
            if (wr) begin
                if (!ctrl_q[LK_CTRL])
                    ctrl_d = (ctrl_q & ~FIELD_MASK[W-1:0]) | (wdata & FIELD_MASK[W-1:0]);
                ctrl_d[L-1:0] = ctrl_q[L-1:0] | wdata[L-1:0];
                if (wdata[LK_CTRL])
                    ctrl_d[L-1:0] = '1;
            end
            for (int i = 0; i < L; i++)
                if (open_req[i]) ctrl_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= LOCK_MASK[W-1:0];
        else     ctrl_q <= ctrl_d;
    end

    // R9
    lock_order_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[LK_CTRL] |-> (ctrl_q[LK_PROG] && ctrl_q[LK_OPT]));
    // R8
    lock_clear_by_key_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(ctrl_q[L-1:0]) & ~ctrl_q[L-1:0] & ~$past(open_req)) == '0));
    // R3
    prog_open_needs_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q[LK_PROG]) |-> !$past(ctrl_q[LK_CTRL]));
    // R7
    fields_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ctrl_q[LK_CTRL]) |-> ((ctrl_q & FIELD_MASK[W-1:0]) == ($past(ctrl_q) & FIELD_MASK[W-1:0])));
    // R7
    undefined_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q & ~(FIELD_MASK[W-1:0] | LOCK_MASK[W-1:0])) == '0);
endmodule

// File: rtl/flash_key_lock.sv
module flash_key_lock
    import fkl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              ctrl_locked,
    output logic              prog_locked,
    output logic              opt_locked,
    output logic              lockout
);
    logic [N_LOCK-1:0] key_hit, key_pass, key_fault, open_req;
    logic              lockout_q, force_lock;
    logic [DATA_W-1:0] ctrl_q;

    for (genvar g = 0; g < N_LOCK; g++) begin : g_key
        localparam key_pair_t KP = key_of(g);
        assign key_hit[g] = wr_en && (addr == key_ofs(g));
        fkl_key_seq #(.W(DATA_W), .FIRST(KP.first), .SECOND(KP.second)) i_seq (
            .clk(clk), .rst(rst), .hit(key_hit[g]), .wdata(wdata),
            .pass(key_pass[g]), .fault(key_fault[g]));
        // program and option locks open only behind an open register lock
        if (g == 0) begin : g_root
            assign open_req[g] = key_pass[g];
        end else begin : g_dep
            assign open_req[g] = key_pass[g] && !ctrl_q[LK_CTRL];
        end
    end

    assign force_lock = lockout_q || (|key_fault);

    always_ff @(posedge clk) begin
        if (rst)            lockout_q <= 1'b0;
        else if (|key_fault) lockout_q <= 1'b1;
    end

    fkl_ctrl_reg #(.W(DATA_W), .L(N_LOCK)) i_ctrl (
        .clk(clk), .rst(rst), .wr(wr_en && (addr == OFS_CTRL)), .wdata(wdata),
        .open_req(open_req), .force_lock(force_lock), .ctrl_q(ctrl_q));

    assign rd_data     = (rd_en && (addr == OFS_CTRL)) ? ctrl_q : '0;
    assign ctrl_word   = ctrl_q;
    assign ctrl_locked = ctrl_q[LK_CTRL];
    assign prog_locked = ctrl_q[LK_PROG];
    assign opt_locked  = ctrl_q[LK_OPT];
    assign lockout     = lockout_q;

    // R6
    lockout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        lockout_q |=> lockout_q);
    // R6
    lockout_holds_locks_chk: assert property (@(posedge clk) disable iff (rst)
        lockout_q |-> (ctrl_q[N_LOCK-1:0] == '1));
    // R4
    opt_open_needs_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q[LK_OPT]) |-> !$past(ctrl_q[LK_CTRL]));
endmodule

// File: tb/test_flash_key_lock.sv
`timescale 1ns/1ps
module test_flash_key_lock;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b1;
    logic [5:0]  addr = 6'h04;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data, ctrl_word;
    logic        ctrl_locked, prog_locked, opt_locked, lockout;

    flash_key_lock i_flash_key_lock (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .ctrl_word(ctrl_word),
        .ctrl_locked(ctrl_locked), .prog_locked(prog_locked),
        .opt_locked(opt_locked), .lockout(lockout));

    always #2.5 clk = ~clk;

    typedef struct {
        logic [31:0] ctrl;
        logic        lk;
        logic [31:0] rd;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // monitor: compare expected items against outputs at falling edges
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [31:0] got_stat, exp_stat;
            e = exp_q.pop_front();
            got_stat = {28'd0, lockout, opt_locked, prog_locked, ctrl_locked};
            exp_stat = {28'd0, e.lk, e.ctrl[2:0]};
            n_checks++;
            if (ctrl_word !== e.ctrl || got_stat !== exp_stat || rd_data !== e.rd) begin
                n_fail++;
                $display("FAIL %s: ctrl=%h stat=%h rd=%h expected ctrl=%h stat=%h rd=%h",
                         e.tag, ctrl_word, got_stat, rd_data, e.ctrl, exp_stat, e.rd);
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = 6'h04;
    endtask

    task automatic expect_st(input logic [31:0] c, input logic lk, input logic [31:0] r, input string tag);
        exp_t e;
        e.ctrl = c; e.lk = lk; e.rd = r; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk); #1;
    endtask

    task automatic do_reset();
        @(negedge clk); #1; rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        expect_st(32'h7, 0, 32'h7, "R1 reset state");

        wr(6'h04, 32'h0007_0718);
        expect_st(32'h7, 0, 32'h7, "R7 fields ignored while locked");
        wr(6'h04, 32'h0);
        expect_st(32'h7, 0, 32'h7, "R8 zero write keeps locks");

        wr(6'h10, 32'h8C9D_AEBF); wr(6'h10, 32'h1314_1516);
        expect_st(32'h7, 0, 32'h7, "R5 program pair while register locked");

        wr(6'h0C, 32'h89AB_CDEF);
        expect_st(32'h7, 0, 32'h7, "R2 first word alone");
        wr(6'h0C, 32'h0203_0405);
        expect_st(32'h6, 0, 32'h6, "R2 register lock open");

        wr(6'h10, 32'h8C9D_AEBF); wr(6'h10, 32'h1314_1516);
        expect_st(32'h4, 0, 32'h4, "R3 program lock open");
        wr(6'h14, 32'hFBEA_D9C8); wr(6'h14, 32'h2425_2627);
        expect_st(32'h0, 0, 32'h0, "R4 option lock open");

        wr(6'h04, 32'hFFFF_FFF8);
        expect_st(32'h0007_0718, 0, 32'h0007_0718, "R7 fields written when open");

        addr = 6'h18;
        expect_st(32'h0007_0718, 0, 32'h0, "R10 other offset reads zero");
        addr = 6'h04;

        wr(6'h04, 32'h0000_0702);
        expect_st(32'h0000_0702, 0, 32'h0000_0702, "R8 set program lock");
        wr(6'h04, 32'h0007_0701);
        expect_st(32'h0007_0707, 0, 32'h0007_0707, "R9 register lock forces others");
        wr(6'h04, 32'h0);
        expect_st(32'h0007_0707, 0, 32'h0007_0707, "R7 frozen after relock");

        wr(6'h0C, 32'h89AB_CDEF); wr(6'h0C, 32'h0203_0405);
        expect_st(32'h0007_0706, 0, 32'h0007_0706, "R2 reopen");
        wr(6'h10, 32'h1314_1516);
        expect_st(32'h0007_0707, 1, 32'h0007_0707, "R6 second word without first");
        wr(6'h0C, 32'h89AB_CDEF); wr(6'h0C, 32'h0203_0405);
        expect_st(32'h0007_0707, 1, 32'h0007_0707, "R6 keys ignored in lockout");

        do_reset();
        expect_st(32'h7, 0, 32'h7, "R1 reset clears lockout");
        wr(6'h14, 32'h1234_5678);
        expect_st(32'h7, 1, 32'h7, "R6 wrong option key value");

        do_reset();
        wr(6'h0C, 32'h89AB_CDEF); wr(6'h0C, 32'h89AB_CDEF);
        expect_st(32'h7, 1, 32'h7, "R6 first word repeated");

        do_reset();
        wr(6'h0C, 32'h89AB_CDEF); wr(6'h0C, 32'h0203_0405);
        wr(6'h14, 32'hFBEA_D9C8); wr(6'h14, 32'h2425_2627);
        expect_st(32'h2, 0, 32'h2, "R4 option open leaves program locked");

        repeat (2) @(negedge clk);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: R1 run did not finish, got timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule